// File: doc/BRIEF.md
# GPIO Port Data and Direction Register File

This block is the register file of a 32-pin general-purpose I/O port. A processor reaches it over a simple memory-mapped bus with a write strobe, a read strobe, a byte address and 32-bit data. Each pin has one bit in every register. A data register holds the value driven onto the pins, and a direction register decides which pins are outputs. A read-only register returns the synchronized pin levels.

Three write-only alias addresses sit beside the data register. One sets chosen output bits, one clears them and one inverts them. A single bus write then changes any group of pins, and the other bits keep their values. Software needs no read-modify-write and no lock when several agents share the port. The output value and the output enable of each pin come straight from registers, so a write appears on the pins on the clock edge that accepts it.

Top module: `gpio_port_regs`

## Requirements
- R1: While the synchronous active-high reset is asserted, and after it is released, pin_out, pin_oe and bus_rdata are all zero. Every pin starts as an input driving 0.
- R2: A write to offset 0x00 loads the whole output data register with bus_wdata. A read of 0x00 returns the register.
- R3: A write to offset 0x04 sets to 1 each output data bit whose bus_wdata bit is 1. All other bits keep their values.
- R4: A write to offset 0x08 clears to 0 each output data bit whose bus_wdata bit is 1. All other bits keep their values.
- R5: A write to offset 0x0C inverts each output data bit whose bus_wdata bit is 1. All other bits keep their values.
- R6: A write to offset 0x14 loads the direction register, and a read of 0x14 returns it. pin_oe equals the direction register, where 1 means output.
- R7: A read of offset 0x10 returns pin_in after a two-flop synchronizer. A level applied before clock edge k is returned by a read whose strobe is sampled at edge k+2. Reads sampled at edges k and k+1 still return the earlier level.
- R8: Reads of 0x04, 0x08, 0x0C and of any unmapped offset return zero. Writes to 0x10 and to unmapped offsets change neither register.
- R9: bus_rdata is registered. A read strobe sampled at a clock edge presents its data after that edge. bus_rdata is zero in any cycle that follows an edge with no read. A read and a write to the same register at the same edge return the value from before the write.
- R10: pin_out equals the output data register and takes a written value on the edge that accepts the write, whatever the direction bits are. With no write strobe, pin_out and pin_oe hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Registered read data |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Value driven on each pin |
| pin_oe | output | NPINS (32) | Output enable of each pin, 1 drives the pin |

## Verification
On every cycle, the assertions check the bit arithmetic of the set, clear and toggle aliases against the previous pin_out. They also check that the outputs hold when no write occurs, that the aliases read as zero, that idle cycles clear the read data and that the direction register reads back. Some behaviours only the bench scenarios can show. These are the two-edge latency of the input synchronizer, a write to the read-only input offset, an access to an unmapped offset, and a read that returns old data when a write to the same register shares its edge. The bench compares a behavioural model with the design on every clock, through directed sequences and a long stretch of random traffic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TGL,
    SEL_IN,
    SEL_DIR,
    SEL_NONE
  } gp_sel_e;

  localparam logic [31:0] OFS_DATA = 32'h00;
  localparam logic [31:0] OFS_SET  = 32'h04;
  localparam logic [31:0] OFS_CLR  = 32'h08;
  localparam logic [31:0] OFS_TGL  = 32'h0C;
  localparam logic [31:0] OFS_IN   = 32'h10;
  localparam logic [31:0] OFS_DIR  = 32'h14;

  function automatic gp_sel_e gp_decode(input logic [31:0] a);
    gp_sel_e s;
    case (a)
      OFS_DATA: s = SEL_DATA;
      OFS_SET:  s = SEL_SET;
      OFS_CLR:  s = SEL_CLR;
      OFS_TGL:  s = SEL_TGL;
      OFS_IN:   s = SEL_IN;
      OFS_DIR:  s = SEL_DIR;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  gp_sel_e      sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_DATA: out_q <= wdata;
        SEL_SET:  out_q <= out_q | wdata;
        SEL_CLR:  out_q <= out_q & ~wdata;
        SEL_TGL:  out_q <= out_q ^ wdata;
        SEL_DIR:  dir_q <= wdata;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         re,
  input  gp_sel_e      sel,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] rdata
);

  logic [W-1:0] mux;

  always_comb begin
    case (sel)
      SEL_DATA: mux = out_q;
      SEL_IN:   mux = in_q;
      SEL_DIR:  mux = dir_q;
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mux;
    else         rdata <= '0;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  gp_sel_e          sel;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] in_q;

  assign sel = gp_decode(32'(bus_addr));

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (in_q)
  );

  gpio_out_regs #(.W(NPINS)) i_out (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .sel   (sel),
    .wdata (bus_wdata),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpio_rd_path #(.W(NPINS)) i_rd (
    .clk   (clk),
    .rst   (rst),
    .re    (bus_re),
    .sel   (sel),
    .out_q (out_q),
    .dir_q (dir_q),
    .in_q  (in_q),
    .rdata (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);

  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(gpio_port_pkg::OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(gpio_port_pkg::OFS_CLR);
  localparam logic [ADDR_W-1:0] A_TGL = ADDR_W'(gpio_port_pkg::OFS_TGL);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(gpio_port_pkg::OFS_DIR);

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

  p_tgl_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_TGL) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

  p_dir_readback_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == A_DIR) |=> (bus_rdata == $past(pin_oe)));

  p_alias_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr == A_SET || bus_addr == A_CLR || bus_addr == A_TGL))
      |=> (bus_rdata == '0));

  p_idle_rdata_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;

  localparam int unsigned NP = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_port_regs #(.NPINS(NP), .ADDR_W(AW)) i_gpio_port_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  logic [NP-1:0] m_out = '0, m_dir = '0, m_rd = '0;
  logic [NP-1:0] m_syn[$] = '{32'h0, 32'h0};
  bit started = 0;

  always @(posedge clk) begin
    logic [NP-1:0] rv;
    started = 1;
    rv = '0;
    case (int'(bus_addr))
      'h00: rv = m_out;
      'h10: rv = m_syn[0];
      'h14: rv = m_dir;
      default: rv = '0;
    endcase
    if (rst) begin
      m_out = '0; m_dir = '0; m_rd = '0;
      m_syn = '{32'h0, 32'h0};
    end else begin
      m_rd = bus_re ? rv : '0;
      if (bus_we) begin
        case (int'(bus_addr))
          'h00: m_out = bus_wdata;
          'h04: m_out = m_out | bus_wdata;
          'h08: m_out = m_out & ~bus_wdata;
          'h0C: m_out = m_out ^ bus_wdata;
          'h14: m_dir = bus_wdata;
          default: ;
        endcase
      end
      void'(m_syn.pop_front());
      m_syn.push_back(pin_in);
    end
  end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R10 model pin_out", pin_out, m_out);
      chk("R6 model pin_oe", pin_oe, m_dir);
      chk("R9 model bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NP-1:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset pin_out", pin_out, '0);
    chk("R1 reset pin_oe", pin_oe, '0);
    chk("R1 reset rdata", bus_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release pin_out", pin_out, '0);

    wr(8'h00, 32'hA5A5_0F0F);
    chk("R2 R10 data write on pins (inputs)", pin_out, 32'hA5A5_0F0F);
    rd(8'h00, d);
    chk("R2 data readback", d, 32'hA5A5_0F0F);

    wr(8'h04, 32'h0000_F0F0);
    chk("R3 set alias", pin_out, 32'hA5A5_FFFF);
    wr(8'h08, 32'hFF00_000F);
    chk("R4 clear alias", pin_out, 32'h00A5_FFF0);
    wr(8'h0C, 32'h0F0F_0F0F);
    chk("R5 toggle alias", pin_out, 32'h0FAA_F0FF);

    wr(8'h14, 32'hFFFF_0000);
    chk("R6 pin_oe follows direction", pin_oe, 32'hFFFF_0000);
    rd(8'h14, d);
    chk("R6 direction readback", d, 32'hFFFF_0000);

    // synchronizer latency: change pin level and read at once
    @(negedge clk);
    pin_in = 32'h1234_5678;
    bus_re = 1'b1; bus_addr = 8'h10;
    @(negedge clk);
    chk("R7 input read at edge k old", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R7 input read at edge k+1 old", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R7 input read at edge k+2 new", bus_rdata, 32'h1234_5678);
    bus_re = 1'b0;

    wr(8'h10, 32'hFFFF_FFFF);
    chk("R8 write to input offset keeps pin_out", pin_out, 32'h0FAA_F0FF);
    chk("R8 write to input offset keeps pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h10, d);
    chk("R8 input register unchanged by write", d, 32'h1234_5678);
    rd(8'h04, d); chk("R8 set alias reads zero", d, '0);
    rd(8'h08, d); chk("R8 clear alias reads zero", d, '0);
    rd(8'h0C, d); chk("R8 toggle alias reads zero", d, '0);
    rd(8'h18, d); chk("R8 unmapped reads zero", d, '0);
    wr(8'h18, 32'hDEAD_BEEF);
    chk("R8 unmapped write keeps pin_out", pin_out, 32'h0FAA_F0FF);
    chk("R8 unmapped write keeps pin_oe", pin_oe, 32'hFFFF_0000);

    // read and write of the data register at the same edge
    @(negedge clk);
    bus_we = 1'b1; bus_re = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h5555_AAAA;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R9 read beside write returns old", bus_rdata, 32'h0FAA_F0FF);
    chk("R10 pin_out takes write", pin_out, 32'h5555_AAAA);
    @(negedge clk);
    chk("R9 idle cycle rdata zero", bus_rdata, '0);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_we = 1'($urandom);
      bus_re = 1'($urandom);
      bus_addr = AW'(($urandom % 7) * 4);
      bus_wdata = $urandom;
      if (($urandom % 8) == 0) pin_in = $urandom;
    end
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule